// File: doc/BRIEF.md
# Scan-Driven Lateral Inhibition Pulse Controller

This controller runs a two-dimensional array of integrate-and-fire neurons that share one spike output and one inhibition line. Two external shift-register chains pick the active neuron. The controller pushes a single pulse into the column chain and a single pulse into the row chain, and only the neuron where both pulses sit is selected. The selection moves to the next neuron once per time step. A time step lasts `STEP_CLKS` controller clocks (10 by default), and columns advance first.

On the first clock of a step the controller samples the spike flag of the selected neuron. A spike from a neuron that carries no inhibition mark starts an inhibition round. The firing neuron gets the longest pulse, `STEP_CLKS-1` clocks, which clears its membrane. Each later neuron, as the scan reaches it, gets a shorter pulse. Its width is a systematic offset taken from the position in the round plus a pseudo-random term from a seedable LFSR. So the membranes are left at scattered levels. Each pulse marks its neuron. The marks clear once every neuron has been scanned since the trigger.

A spike is reported as an event carrying its row and column. The event leaves on a valid/ready output. `ev_valid` rises on the last clock of the step and stays high, with stable data, until `ev_ready` is seen. The event port holds one event. A spike that arrives while an earlier event is still waiting is dropped. Back-pressure never stalls the scan or the inhibition timing.

Top module: `inhib_scan_ctrl`

## Requirements
- R1: `col_shift` is high for exactly one clock, the last clock of each step. When the step's column index is `NCOL-1`, `col_din` and `row_shift` are high on that clock. When the row index is also `NROW-1`, `row_din` is high as well. Otherwise these three are low.
- R2: After reset, all outputs are low. The first step is a loading step: a spike during it gives no event and no pulse. The next step selects row 0, column 0.
- R3: A spike from an unmarked neuron starts a round. That neuron's inhibition pulse is exactly `STEP_CLKS-1` clocks long and starts on the second clock of the step.
- R4: Every neuron scanned after the trigger in an active round gets one pulse of 1 to `STEP_CLKS-2` clocks, starting on the second clock of its step.
- R5: A round covers `NCOL*NROW` consecutive steps: the trigger step and every other neuron once. The step after the round gives no pulse unless it starts a new round.
- R6: A spike from a neuron already marked in the current round produces an event. It does not restart the round: the neuron gets a normal follower pulse and the round end does not move.
- R7: A spike from an unmarked neuron during an active round restarts the round from that neuron. It gets the full-width pulse, and the round length is counted again from it.
- R8: An accepted spike appears as `ev_valid` on the last clock of its step, with `ev_row`/`ev_col` equal to the zero-based row and column of the firing neuron.
- R9: While `ev_valid` is high and `ev_ready` is low, `ev_valid`, `ev_row` and `ev_col` hold. A spike whose event falls due in that time is dropped.
- R10: Pulsing `seed_load` loads `seed_val` into the LFSR, and an all-zero value loads as 1. Loading the same seed before two rounds gives the same follower width sequence.
- R11: `inh_out` is low on the first clock of every step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| seed_load | input | 1 | Load `seed_val` into the LFSR |
| seed_val | input | LFSR_W | LFSR seed |
| spike_in | input | 1 | Spike flag of the selected neuron |
| col_shift | output | 1 | Column chain shift strobe |
| col_din | output | 1 | Data bit shifted into the column chain |
| row_shift | output | 1 | Row chain shift strobe |
| row_din | output | 1 | Data bit shifted into the row chain |
| inh_out | output | 1 | Shared inhibition line |
| ev_valid | output | 1 | Spike event valid |
| ev_ready | input | 1 | Spike event accepted |
| ev_row | output | $clog2(NROW) | Row of the firing neuron |
| ev_col | output | $clog2(NCOL) | Column of the firing neuron |

## Verification
The hardest state to reach is a neuron that spikes while it still carries a mark from an earlier round. Marks clear before the scan returns to a neuron, unless a restart has pushed the round end forward. The stimulus triggers a round, then restarts it from a neuron a few steps further on. After a full lap it spikes a neuron that lies between the two triggers, which hits the marked-spike path and lands just before the moved round end. A second difficulty is showing that the random widths are repeatable. The bench loads one seed before two separate rounds and compares the logged width sequences.

// File: rtl/inhib_pkg.sv
package inhib_pkg;
  // Kind of pulse decided for the current step.
  typedef enum logic [1:0] {
    PW_NONE   = 2'd0,
    PW_FULL   = 2'd1,
    PW_FOLLOW = 2'd2
  } pw_kind_t;
endpackage

// File: rtl/scan_sequencer.sv
module scan_sequencer #(
  parameter int NCOL      = 30,
  parameter int NROW      = 7,
  parameter int STEP_CLKS = 10,
  localparam int CW = $clog2(NCOL),
  localparam int RW = $clog2(NROW),
  localparam int PW = $clog2(STEP_CLKS)
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [CW-1:0] col_idx,
  output logic [RW-1:0] row_idx,
  output logic          primed,
  output logic          step_start,
  output logic          step_pre_end,
  output logic          step_end,
  output logic          col_shift,
  output logic          col_din,
  output logic          row_shift,
  output logic          row_din
);
  localparam logic [PW-1:0] PH_LAST = PW'(STEP_CLKS - 1);
  localparam logic [PW-1:0] PH_PRE  = PW'(STEP_CLKS - 2);
  localparam logic [CW-1:0] COL_END = CW'(NCOL - 1);
  localparam logic [RW-1:0] ROW_END = RW'(NROW - 1);

  logic [PW-1:0] phase;
  logic          col_wrap;

  assign step_start   = (phase == '0);
  assign step_pre_end = (phase == PH_PRE);
  assign step_end     = (phase == PH_LAST);
  assign col_wrap     = (col_idx == COL_END);

  assign col_shift = step_end;
  assign col_din   = step_end && col_wrap;
  assign row_shift = step_end && col_wrap;
  assign row_din   = step_end && col_wrap && (row_idx == ROW_END);

  // Reset points at the last neuron so the first step ends by injecting
  // both enable pulses; that step is the loading step.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase   <= '0;
      col_idx <= COL_END;
      row_idx <= ROW_END;
      primed  <= 1'b0;
    end else begin
      phase <= step_end ? '0 : phase + 1'b1;
      if (step_end) begin
        primed <= 1'b1;
        if (col_wrap) begin
          col_idx <= '0;
          row_idx <= (row_idx == ROW_END) ? '0 : row_idx + 1'b1;
        end else begin
          col_idx <= col_idx + 1'b1;
        end
      end
    end
  end

  a_r1_shift_single: assert property (@(posedge clk) disable iff (!rst_n)
    col_shift |=> !col_shift);
  a_r1_col_wraps: assert property (@(posedge clk) disable iff (!rst_n)
    (col_shift && col_idx == COL_END) |=> (col_idx == '0));
  a_r1_row_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !row_shift |=> $stable(row_idx));
endmodule

// File: rtl/seed_lfsr.sv
module seed_lfsr #(
  parameter int              LFSR_W = 16,
  parameter logic [LFSR_W-1:0] TAPS = 16'hB400
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              seed_load,
  input  logic [LFSR_W-1:0] seed_val,
  input  logic              advance,
  output logic [2:0]        rnd
);
  logic [LFSR_W-1:0] state;
  logic              fb;

  assign fb  = ^(state & TAPS);
  assign rnd = state[2:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= LFSR_W'(1);
    end else if (seed_load) begin
      state <= (seed_val == '0) ? LFSR_W'(1) : seed_val;
    end else if (advance) begin
      state <= {state[LFSR_W-2:0], fb};
    end
  end

  a_r10_never_zero: assert property (@(posedge clk) disable iff (!rst_n)
    state != '0);
  a_r10_seed_taken: assert property (@(posedge clk) disable iff (!rst_n)
    (seed_load && seed_val != '0) |=> (state == $past(seed_val)));
endmodule

// File: rtl/round_ctrl.sv
module round_ctrl
  import inhib_pkg::*;
#(
  parameter int NCOL      = 30,
  parameter int NROW      = 7,
  parameter int STEP_CLKS = 10,
  localparam int CW    = $clog2(NCOL),
  localparam int RW    = $clog2(NROW),
  localparam int TOTAL = NCOL * NROW,
  localparam int NW    = $clog2(TOTAL),
  localparam int WW    = $clog2(STEP_CLKS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step_start,
  input  logic          primed,
  input  logic          spike_in,
  input  logic [CW-1:0] col_idx,
  input  logic [RW-1:0] row_idx,
  input  logic [2:0]    rnd,
  output pw_kind_t      kind,
  output logic [WW-1:0] width,
  output logic          advance,
  output logic          fire
);
  localparam int SW = WW + 3;
  localparam logic [WW-1:0] W_FULL  = WW'(STEP_CLKS - 1);
  localparam logic [SW-1:0] W_CAP   = SW'(STEP_CLKS - 2);
  localparam logic [NW-1:0] CNT_END = NW'(TOTAL - 1);

  logic [TOTAL-1:0] marks;
  logic             active;
  logic [NW-1:0]    rcnt;
  logic [NW-1:0]    idx;
  logic             spk, hit, trig, foll;
  logic [SW-1:0]    fsum;
  logic [WW-1:0]    fwidth;

  // Row-major neuron number of the selected neuron.
  assign idx  = NW'(row_idx) * NW'(NCOL) + NW'(col_idx);
  assign spk  = spike_in && primed;
  assign hit  = marks[idx];
  assign trig = step_start && spk && !hit;
  assign foll = step_start && !trig && active;

  // Systematic part from the round position, random part from the LFSR.
  assign fsum   = SW'(rcnt[1:0]) + SW'(rnd) + SW'(1);
  assign fwidth = (fsum > W_CAP) ? W_CAP[WW-1:0] : fsum[WW-1:0];

  always_comb begin
    kind  = PW_NONE;
    width = '0;
    if (trig) begin
      kind  = PW_FULL;
      width = W_FULL;
    end else if (foll) begin
      kind  = PW_FOLLOW;
      width = fwidth;
    end
  end

  assign advance = foll;
  assign fire    = step_start && spk;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      marks  <= '0;
      active <= 1'b0;
      rcnt   <= '0;
    end else if (trig) begin
      active     <= 1'b1;
      rcnt       <= NW'(1);
      marks[idx] <= 1'b1;
    end else if (foll) begin
      if (rcnt == CNT_END) begin
        marks  <= '0;
        active <= 1'b0;
        rcnt   <= '0;
      end else begin
        marks[idx] <= 1'b1;
        rcnt       <= rcnt + 1'b1;
      end
    end
  end

  a_r5_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> (rcnt != '0) && (rcnt <= CNT_END));
  a_r4_follow_range: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == PW_FOLLOW) |-> (width != '0) && (SW'(width) <= W_CAP));
  a_r6_marked_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (step_start && spk && hit) |-> (kind != PW_FULL));
  a_r5_idle_clean: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> (marks == '0));
endmodule

// File: rtl/pulse_timer.sv
module pulse_timer #(
  parameter int STEP_CLKS = 10,
  localparam int WW = $clog2(STEP_CLKS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [WW-1:0] width,
  output logic          inh_out
);
  logic [WW-1:0] left;

  assign inh_out = (left != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      left <= '0;
    end else if (load) begin
      left <= width;
    end else if (left != '0) begin
      left <= left - 1'b1;
    end
  end

  a_r3_counts_down: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && left != '0) |=> (left == $past(left) - 1'b1));
endmodule

// File: rtl/event_port.sv
module event_port #(
  parameter int NCOL = 30,
  parameter int NROW = 7,
  localparam int CW = $clog2(NCOL),
  localparam int RW = $clog2(NROW)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step_start,
  input  logic          step_pre_end,
  input  logic          fire,
  input  logic [CW-1:0] col_idx,
  input  logic [RW-1:0] row_idx,
  output logic          ev_valid,
  input  logic          ev_ready,
  output logic [RW-1:0] ev_row,
  output logic [CW-1:0] ev_col
);
  logic          pend;
  logic [RW-1:0] pr;
  logic [CW-1:0] pc;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend     <= 1'b0;
      pr       <= '0;
      pc       <= '0;
      ev_valid <= 1'b0;
      ev_row   <= '0;
      ev_col   <= '0;
    end else begin
      if (step_start) begin
        pend <= fire;
        pr   <= row_idx;
        pc   <= col_idx;
      end
      if (ev_valid && ev_ready) ev_valid <= 1'b0;
      if (step_pre_end && pend) begin
        pend <= 1'b0;
        // One slot: a waiting event wins, the newer spike is dropped.
        if (!ev_valid || ev_ready) begin
          ev_valid <= 1'b1;
          ev_row   <= pr;
          ev_col   <= pc;
        end
      end
    end
  end

  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_valid && !ev_ready) |=> ev_valid && $stable(ev_row) && $stable(ev_col));
  a_r8_rise_at_end: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ev_valid) |-> $past(step_pre_end));
endmodule

// File: rtl/inhib_scan_ctrl.sv
module inhib_scan_ctrl
  import inhib_pkg::*;
#(
  parameter int NCOL      = 30,
  parameter int NROW      = 7,
  parameter int STEP_CLKS = 10,
  parameter int LFSR_W    = 16,
  parameter logic [LFSR_W-1:0] LFSR_TAPS = 16'hB400
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     seed_load,
  input  logic [LFSR_W-1:0]        seed_val,
  input  logic                     spike_in,
  output logic                     col_shift,
  output logic                     col_din,
  output logic                     row_shift,
  output logic                     row_din,
  output logic                     inh_out,
  output logic                     ev_valid,
  input  logic                     ev_ready,
  output logic [$clog2(NROW)-1:0]  ev_row,
  output logic [$clog2(NCOL)-1:0]  ev_col
);
  localparam int CW = $clog2(NCOL);
  localparam int RW = $clog2(NROW);
  localparam int WW = $clog2(STEP_CLKS);

  logic [CW-1:0] col_idx;
  logic [RW-1:0] row_idx;
  logic          primed, step_start, step_pre_end, step_end;
  logic [2:0]    rnd;
  pw_kind_t      kind;
  logic [WW-1:0] width;
  logic          advance, fire;

  scan_sequencer #(.NCOL(NCOL), .NROW(NROW), .STEP_CLKS(STEP_CLKS)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .col_idx(col_idx), .row_idx(row_idx), .primed(primed),
    .step_start(step_start), .step_pre_end(step_pre_end), .step_end(step_end),
    .col_shift(col_shift), .col_din(col_din),
    .row_shift(row_shift), .row_din(row_din)
  );

  seed_lfsr #(.LFSR_W(LFSR_W), .TAPS(LFSR_TAPS)) u_rng (
    .clk(clk), .rst_n(rst_n),
    .seed_load(seed_load), .seed_val(seed_val),
    .advance(advance), .rnd(rnd)
  );

  round_ctrl #(.NCOL(NCOL), .NROW(NROW), .STEP_CLKS(STEP_CLKS)) u_round (
    .clk(clk), .rst_n(rst_n),
    .step_start(step_start), .primed(primed), .spike_in(spike_in),
    .col_idx(col_idx), .row_idx(row_idx), .rnd(rnd),
    .kind(kind), .width(width), .advance(advance), .fire(fire)
  );

  pulse_timer #(.STEP_CLKS(STEP_CLKS)) u_pulse (
    .clk(clk), .rst_n(rst_n),
    .load(step_start), .width(width), .inh_out(inh_out)
  );

  event_port #(.NCOL(NCOL), .NROW(NROW)) u_ev (
    .clk(clk), .rst_n(rst_n),
    .step_start(step_start), .step_pre_end(step_pre_end), .fire(fire),
    .col_idx(col_idx), .row_idx(row_idx),
    .ev_valid(ev_valid), .ev_ready(ev_ready),
    .ev_row(ev_row), .ev_col(ev_col)
  );

  a_r11_quiet_first_clock: assert property (@(posedge clk) disable iff (!rst_n)
    step_start |-> !inh_out);
  a_r3_full_starts: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == PW_FULL) |=> inh_out);
  a_r2_loading_silent: assert property (@(posedge clk) disable iff (!rst_n)
    !primed |-> (kind == PW_NONE) && !fire);
  a_r11_pulse_ends_in_step: assert property (@(posedge clk) disable iff (!rst_n)
    step_end |=> !inh_out);
endmodule

// File: tb/test_inhib_scan_ctrl.sv
module test_inhib_scan_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int NCOL  = 30;
  localparam int NROW  = 7;
  localparam int STEP  = 10;
  localparam int TOTAL = NCOL * NROW;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        seed_load = 1'b0;
  logic [15:0] seed_val = '0;
  logic        spike_in = 1'b0;
  logic        col_shift, col_din, row_shift, row_din, inh_out, ev_valid;
  logic        ev_ready = 1'b1;
  logic [2:0]  ev_row;
  logic [4:0]  ev_col;

  inhib_scan_ctrl i_inhib_scan_ctrl (
    .clk(clk), .rst_n(rst_n), .seed_load(seed_load), .seed_val(seed_val),
    .spike_in(spike_in), .col_shift(col_shift), .col_din(col_din),
    .row_shift(row_shift), .row_din(row_din), .inh_out(inh_out),
    .ev_valid(ev_valid), .ev_ready(ev_ready), .ev_row(ev_row), .ev_col(ev_col)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  typedef struct {
    int    row;
    int    col;
    int    kind;   // 0 none, 1 full, 2 follower
    bit    ev;
    bit    chk;
    int    rec;
    string tag;
  } item_t;

  item_t sbq[$];
  int    log1[$];
  int    log2[$];
  int    errors = 0;
  int    checks = 0;
  bit    done = 1'b0;

  // Requirement-level model of the scan position and round state.
  int mr = 0, mc = 0;
  bit mmark[TOTAL];
  bit mact = 1'b0;
  int mcnt = 0;

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // Driver: sets the spike for the step about to start and pushes its expectation.
  task automatic step(input bit s, input string tag = "", input bit chk = 1'b1,
                      input int rec = 0);
    item_t it;
    int    idx;
    @(negedge clk iff col_shift);
    #1;
    spike_in = s;
    idx = mr * NCOL + mc;
    it.row = mr; it.col = mc; it.ev = s; it.chk = chk; it.rec = rec;
    if (s && !mmark[idx]) begin
      it.kind = 1; mact = 1'b1; mcnt = 1; mmark[idx] = 1'b1;
    end else if (mact) begin
      it.kind = 2;
      if (mcnt == TOTAL - 1) begin
        foreach (mmark[k]) mmark[k] = 1'b0;
        mact = 1'b0; mcnt = 0;
      end else begin
        mmark[idx] = 1'b1; mcnt++;
      end
    end else begin
      it.kind = 0;
    end
    if (tag != "") it.tag = tag;
    else it.tag = (it.kind == 1) ? "R3" : (it.kind == 2) ? "R4" : "R5";
    sbq.push_back(it);
    if (mc == NCOL - 1) begin
      mc = 0;
      mr = (mr == NROW - 1) ? 0 : mr + 1;
    end else begin
      mc++;
    end
  endtask

  // Monitor: measures each step and compares with the front of the queue.
  initial begin
    int  wcnt = 0;
    bit  evs = 1'b0;
    int  er = 0, ec = 0;
    item_t it;
    forever begin
      @(negedge clk);
      if (!rst_n) begin
        wcnt = 0; evs = 1'b0;
      end else begin
        if (inh_out) wcnt++;
        if (ev_valid && ev_ready) begin evs = 1'b1; er = ev_row; ec = ev_col; end
        if (col_shift) begin
          if (sbq.size() > 0) begin
            it = sbq.pop_front();
            if (it.chk) begin
              if (it.kind == 1)
                check(wcnt == STEP - 1, it.tag, "full pulse width", wcnt, STEP - 1);
              else if (it.kind == 2)
                check(wcnt >= 1 && wcnt <= STEP - 2, it.tag,
                      "follower width (range 1..STEP-2)", wcnt, STEP - 2);
              else
                check(wcnt == 0, it.tag, "no pulse width", wcnt, 0);
              check(evs == it.ev, "R8", {it.tag, " event seen"}, evs, it.ev);
              if (it.ev && evs) begin
                check(er == it.row, "R8", "event row", er, it.row);
                check(ec == it.col, "R8", "event column", ec, it.col);
              end
              check(col_din == (it.col == NCOL - 1), "R1", "col_din", col_din,
                    it.col == NCOL - 1);
              check(row_shift == (it.col == NCOL - 1), "R1", "row_shift", row_shift,
                    it.col == NCOL - 1);
              check(row_din == (it.col == NCOL - 1 && it.row == NROW - 1), "R1",
                    "row_din", row_din, it.col == NCOL - 1 && it.row == NROW - 1);
            end
            if (it.rec == 1) log1.push_back(wcnt);
            if (it.rec == 2) log2.push_back(wcnt);
          end
          wcnt = 0; evs = 1'b0;
        end
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    item_t ld;
    int    ar, ac;
    spike_in = 1'b1;   // spike held through the loading step (R2)
    repeat (4) @(negedge clk);
    check(!col_shift && !inh_out && !ev_valid, "R2", "outputs in reset",
          {col_shift, inh_out, ev_valid}, 0);
    ld.row = NROW - 1; ld.col = NCOL - 1; ld.kind = 0; ld.ev = 1'b0;
    ld.chk = 1'b1; ld.rec = 0; ld.tag = "R2";
    sbq.push_back(ld);
    rst_n = 1'b1;

    // Trigger, restart, marked spike on the next lap, round end.
    for (int i = 0; i < TOTAL + 20; i++) begin
      if (i == 3)               step(1'b1, "R3");
      else if (i == 10)         step(1'b1, "R7");
      else if (i == TOTAL + 5)  step(1'b1, "R6");
      else if (i == TOTAL + 10) step(1'b0, "R5");
      else if (i == 0)          step(1'b0, "R2");
      else                      step(1'b0);
    end

    // Same seed before two rounds gives the same width sequence.
    for (int pass = 1; pass <= 2; pass++) begin
      seed_val  = 16'h5A3C;
      seed_load = 1'b1;
      @(negedge clk); #1;
      seed_load = 1'b0;
      step(1'b1, "R3");
      for (int i = 0; i < 40; i++) step(1'b0, "R10", 1'b1, pass);
      for (int i = 0; i < TOTAL - 30; i++) step(1'b0);
    end
    check(log1.size() == 40 && log2.size() == 40, "R10", "logged widths",
          log2.size(), 40);
    for (int i = 0; i < 40 && i < log1.size() && i < log2.size(); i++)
      check(log1[i] == log2[i], "R10", "repeat width", log2[i], log1[i]);

    // Back-pressure: first event holds, the second is dropped.
    ev_ready = 1'b0;
    ar = mr; ac = mc;
    step(1'b1, "R9", 1'b0);
    step(1'b1, "R9", 1'b0);
    step(1'b0, "R9", 1'b0);
    check(ev_valid == 1'b1, "R9", "held valid", ev_valid, 1);
    check(ev_row == ar, "R9", "held row", ev_row, ar);
    check(ev_col == ac, "R9", "held column", ev_col, ac);
    ev_ready = 1'b1;
    @(negedge clk);
    check(ev_valid == 1'b0, "R9", "second event dropped", ev_valid, 0);
    step(1'b0, "", 1'b0);
    step(1'b0, "", 1'b0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule